// File: doc/BRIEF.md
# Three-Wire Serial Control Register Interface

This block receives 16-bit control words on a three-wire serial bus made of a data line, a serial clock and an enable line. While enable is low, each rising serial clock edge shifts one data bit into a 16-bit shift register, most significant bit first. A rising edge on enable commits the word. Bit 0 of the word is an address bit, and the other 15 bits go to one of two registers. Address 0 selects a one-time setup register. Address 1 selects an operating-mode register, which carries the channel divider word and the per-section power enables, so a single write changes both channel and power state.

The serial pins are asynchronous to the block clock. They are oversampled through synchronizer chains, and their edges are detected in the block clock domain. The decoded fields of both registers are presented as parallel outputs. A valid flag shows that the setup register has been written at least once.

Top module: `serial_ctrl_if`

## Requirements
- R1: After reset every setup field, every mode field and cfg_valid_o are 0.
- R2: While enable is low, each rising serial clock edge shifts sdata_i into the word, most significant bit first. A rising edge of enable commits the word once exactly 16 bits have been shifted.
- R3: A committed word with bit 0 = 0 loads bits 15..1 into the setup register. A committed word with bit 0 = 1 loads bits 15..1 into the mode register.
- R4: Setup field positions in the word are as follows. Bit 15 is unused. rx_pol_o=14, tx_pol_o=13, syn_pol_o=12, rx_div_mode_o=11..10, tx_div_on_o=9, band_pol_o=8, ext_ctrl_o=7, cp_test_o=6..5, slicer_on_o=4, sfield_on_o=3, pfd_pol_o=2, ref_sel_o=1.
- R5: Mode field positions in the word are as follows. m_sel_o=15, a_count_o=14..10, and pwr_en_o[8:0] = word bits 9..1. Word bit 9 is the IF/RSSI strip and word bit 1 is the regulators.
- R6: A write to one register leaves the other register unchanged. Both registers hold their contents until they are overwritten or the block is reset.
- R7: cfg_valid_o rises with the first setup-register write and then stays high. Mode-register writes do not set it.
- R8: If enable rises after fewer than 16 bits have been shifted since enable last fell, the partial word is discarded and both registers are unchanged.
- R9: Serial clock edges that occur while enable is high are not shifted and are not counted toward the 16 bits.
- R10: If more than 16 bits are shifted before enable rises, the last 16 bits form the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| sen_i | input | 1 | Serial enable; low frames a word, rising edge commits it |
| rx_pol_o | output | 1 | Receive control line polarity |
| tx_pol_o | output | 1 | Transmit control line polarity |
| syn_pol_o | output | 1 | Synthesizer control line polarity |
| rx_div_mode_o | output | 2 | Divider mode in an active receive slot |
| tx_div_on_o | output | 1 | Divider mode in an active transmit slot |
| band_pol_o | output | 1 | Band switch polarity |
| ext_ctrl_o | output | 1 | Mode control taken from external lines |
| cp_test_o | output | 2 | Charge pump test mode |
| slicer_on_o | output | 1 | Data slicer enable |
| sfield_on_o | output | 1 | S-field sampling demodulation mode |
| pfd_pol_o | output | 1 | Phase detector sense |
| ref_sel_o | output | 1 | Reference frequency select |
| m_sel_o | output | 1 | M counter ratio select |
| a_count_o | output | 5 | A counter value |
| pwr_en_o | output | 9 | Section power enables, bit 8 IF/RSSI down to bit 0 regulators |
| cfg_valid_o | output | 1 | Setup register has been written since reset |

## Verification
The assertions assume the serial inputs are much slower than the block clock. Each serial clock level and each enable level must last at least SYNC_STAGES+1 block cycles, and data must be stable across the sampled serial clock rise. Under these conditions no edge is lost or merged in the synchronizers. The stimulus holds every serial clock half period for four block cycles, changes data only after a serial clock fall, and moves enable only while the serial clock is low. The random part mixes full words, short words and long words, and inserts stray clocks while enable is high.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef struct packed {
    logic       spare;
    logic       rx_pol;
    logic       tx_pol;
    logic       syn_pol;
    logic [1:0] rx_div;
    logic       tx_div;
    logic       band_pol;
    logic       ext_ctrl;
    logic [1:0] cp_test;
    logic       slicer_on;
    logic       sfield_on;
    logic       pfd_pol;
    logic       ref_sel;
  } setup_t;

  typedef struct packed {
    logic       m_sel;
    logic [4:0] a_count;
    logic [8:0] pwr_en;
  } mode_t;

  localparam logic ADDR_SETUP = 1'b0;
  localparam logic ADDR_MODE  = 1'b1;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= async_i;
      else chain_q[s] <= chain_q[(s > 0) ? s-1 : 0];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sctl_shifter.sv
module sctl_shifter
  import sctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_s_i,
  input  logic              sclk_s_i,
  input  logic              sen_s_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  logic              sclk_d_q, sen_d_q;
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sclk_rise, sen_rise, full;

  assign sclk_rise = sclk_s_i & ~sclk_d_q;
  assign sen_rise  = sen_s_i & ~sen_d_q;
  assign full      = (cnt_q == CNT_W'(WORD_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      sen_d_q  <= 1'b0;
      shift_q  <= '0;
      cnt_q    <= '0;
    end else begin
      sclk_d_q <= sclk_s_i;
      sen_d_q  <= sen_s_i;
      if (sen_s_i) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        shift_q <= {shift_q[WORD_W-2:0], sdata_s_i};
        if (!full) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // a word is only taken once a full frame has been counted
  assign commit_o = sen_rise & full;
  assign word_o   = shift_q;

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WORD_W));
  p_no_count_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_s_i |=> cnt_q == '0);
  p_shift_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && !sen_s_i && !full) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && !sen_s_i) |=> shift_q[0] == $past(sdata_s_i));
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
  import sctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output setup_t            setup_o,
  output mode_t             mode_o,
  output logic              valid_o
);
  setup_t setup_q;
  mode_t  mode_q;
  logic   valid_q;
  logic   wr_setup, wr_mode;

  assign wr_setup = commit_i & (word_i[0] == ADDR_SETUP);
  assign wr_mode  = commit_i & (word_i[0] == ADDR_MODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q <= '0;
      mode_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (wr_setup) begin
        setup_q <= setup_t'(word_i[WORD_W-1:1]);
        valid_q <= 1'b1;
      end
      if (wr_mode) mode_q <= mode_t'(word_i[WORD_W-1:1]);
    end
  end

  assign setup_o = setup_q;
  assign mode_o  = mode_q;
  assign valid_o = valid_q;

  p_valid_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q);
  p_valid_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !word_i[0]) |=> valid_q);
  p_setup_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i && !word_i[0]) |=> $stable(setup_q));
  p_mode_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i && word_i[0]) |=> $stable(mode_q));
  p_mode_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && word_i[0]) |=> mode_q == $past(word_i[WORD_W-1:1]));
endmodule

// File: rtl/serial_ctrl_if.sv
module serial_ctrl_if
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sdata_i,
  input  logic       sclk_i,
  input  logic       sen_i,
  output logic       rx_pol_o,
  output logic       tx_pol_o,
  output logic       syn_pol_o,
  output logic [1:0] rx_div_mode_o,
  output logic       tx_div_on_o,
  output logic       band_pol_o,
  output logic       ext_ctrl_o,
  output logic [1:0] cp_test_o,
  output logic       slicer_on_o,
  output logic       sfield_on_o,
  output logic       pfd_pol_o,
  output logic       ref_sel_o,
  output logic       m_sel_o,
  output logic [4:0] a_count_o,
  output logic [8:0] pwr_en_o,
  output logic       cfg_valid_o
);
  logic [2:0]        pins_s;
  logic              commit;
  logic [WORD_W-1:0] word;
  setup_t            setup;
  mode_t             mode;

  sctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({sen_i, sclk_i, sdata_i}),
    .sync_o (pins_s)
  );

  sctl_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sdata_s_i(pins_s[0]),
    .sclk_s_i (pins_s[1]),
    .sen_s_i  (pins_s[2]),
    .commit_o (commit),
    .word_o   (word)
  );

  sctl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .word_i  (word),
    .setup_o (setup),
    .mode_o  (mode),
    .valid_o (cfg_valid_o)
  );

  assign rx_pol_o      = setup.rx_pol;
  assign tx_pol_o      = setup.tx_pol;
  assign syn_pol_o     = setup.syn_pol;
  assign rx_div_mode_o = setup.rx_div;
  assign tx_div_on_o   = setup.tx_div;
  assign band_pol_o    = setup.band_pol;
  assign ext_ctrl_o    = setup.ext_ctrl;
  assign cp_test_o     = setup.cp_test;
  assign slicer_on_o   = setup.slicer_on;
  assign sfield_on_o   = setup.sfield_on;
  assign pfd_pol_o     = setup.pfd_pol;
  assign ref_sel_o     = setup.ref_sel;
  assign m_sel_o       = mode.m_sel;
  assign a_count_o     = mode.a_count;
  assign pwr_en_o      = mode.pwr_en;

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (!cfg_valid_o && pwr_en_o == '0 && a_count_o == '0));
endmodule

// File: tb/serial_ctrl_if_test.sv
module serial_ctrl_if_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, sen = 1'b1;
  logic rx_pol, tx_pol, syn_pol, tx_div, band_pol, ext_ctrl;
  logic slicer_on, sfield_on, pfd_pol, ref_sel, m_sel, cfg_valid;
  logic [1:0] rx_div, cp_test;
  logic [4:0] a_count;
  logic [8:0] pwr_en;

  int checks = 0, errors = 0, cycles = 0;
  logic [13:0] exp_setup = '0;
  logic [14:0] exp_mode = '0;
  logic exp_valid = 1'b0;

  always #5 clk = ~clk;

  serial_ctrl_if uut (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk), .sen_i(sen),
    .rx_pol_o(rx_pol), .tx_pol_o(tx_pol), .syn_pol_o(syn_pol),
    .rx_div_mode_o(rx_div), .tx_div_on_o(tx_div), .band_pol_o(band_pol),
    .ext_ctrl_o(ext_ctrl), .cp_test_o(cp_test), .slicer_on_o(slicer_on),
    .sfield_on_o(sfield_on), .pfd_pol_o(pfd_pol), .ref_sel_o(ref_sel),
    .m_sel_o(m_sel), .a_count_o(a_count), .pwr_en_o(pwr_en),
    .cfg_valid_o(cfg_valid)
  );

  function automatic logic [13:0] got_setup();
    return {rx_pol, tx_pol, syn_pol, rx_div, tx_div, band_pol, ext_ctrl,
            cp_test, slicer_on, sfield_on, pfd_pol, ref_sel};
  endfunction

  function automatic logic [14:0] got_mode();
    return {m_sel, a_count, pwr_en};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk(logic d);
    sdata = d;
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
  endtask

  // open frame, shift n bits of v MSB first, close frame
  task automatic send(logic [31:0] v, int n);
    sen = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) pulse_sclk(v[i]);
    wait_clk(4);
    sen = 1'b1;
    wait_clk(8);
  endtask

  // expected effect of a frame of n bits
  task automatic model(logic [31:0] v, int n);
    if (n >= 16) begin
      if (v[0]) exp_mode = v[15:1];
      else begin
        exp_setup = v[14:1];
        exp_valid = 1'b1;
      end
    end
  endtask

  task automatic check_all(string req);
    check(req, 32'(got_setup()), 32'(exp_setup));
    check(req, 32'(got_mode()), 32'(exp_mode));
    check(req, 32'(cfg_valid), 32'(exp_valid));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    void'($urandom(1234));
    wait_clk(3);
    check_all("R1 reset");
    rst_n = 1'b1;
    wait_clk(4);

    // R7: mode write first does not set valid; R5 field positions
    v = 32'h0000_ABCD;
    send(v, 16); model(v, 16);
    check("R5 m_sel", 32'(m_sel), 32'(v[15]));
    check("R5 a_count", 32'(a_count), 32'(v[14:10]));
    check("R5 pwr_en", 32'(pwr_en), 32'(v[9:1]));
    check("R7 valid after mode write", 32'(cfg_valid), 32'd0);
    check("R6 setup untouched", 32'(got_setup()), 32'd0);

    // R4 setup field positions; R2 MSB first
    v = 32'h0000_5A5C;
    send(v, 16); model(v, 16);
    check("R4 rx_pol", 32'(rx_pol), 32'(v[14]));
    check("R4 rx_div_mode", 32'(rx_div), 32'(v[11:10]));
    check("R4 cp_test", 32'(cp_test), 32'(v[6:5]));
    check("R4 ref_sel", 32'(ref_sel), 32'(v[1]));
    check("R2 setup word", 32'(got_setup()), 32'(v[14:1]));
    check("R7 valid set", 32'(cfg_valid), 32'd1);
    check("R6 mode kept", 32'(got_mode()), 32'(exp_mode));

    // R8: partial word discarded
    send(32'h0000_03FF, 10);
    check_all("R8 partial discarded");

    // R9: clock while enable high is not counted
    pulse_sclk(1'b1);
    send(32'h0000_7FFF, 15);
    check_all("R9 high-enable clock not counted");

    // R10: last 16 of 20 bits
    v = 32'h000F_1235;
    send(v, 20); model(v, 20);
    check_all("R10 long word");

    // R3 random mix
    for (int k = 0; k < 60; k++) begin
      v = $urandom;
      n = ($urandom % 4 == 0) ? int'($urandom % 21) + 1 : 16;
      if ($urandom % 5 == 0) pulse_sclk(1'($urandom));
      send(v, n); model(v, n);
      check_all("R3 random word");
    end

    // R7: valid stays high across a further mode write
    v = 32'h0000_0001;
    send(v, 16); model(v, 16);
    check("R7 valid sticky", 32'(cfg_valid), 32'd1);
    check_all("R6 retention");
    finish_run();
  end
endmodule